// File: doc/BRIEF.md
# Single-Channel Byte Mover with Windowed Peripheral Port

This block is one channel of a direct memory access engine. It moves bytes one at a time between a wide memory-side bus (the A bus, 24-bit addresses) and a narrow peripheral-side bus (the B bus). On the B bus the channel only reaches a 256-entry register window. Software programs seven byte-wide registers while the channel is idle, then pulses `go`. The channel runs the whole transfer by itself. On each byte it fetches from the source bus, stores to the destination bus, then advances the memory address and the remaining count.

On the B side the target address is a fixed page byte joined to an 8-bit window index. That index is the programmed port number plus an offset, and the transfer mode and the parity of the byte index choose the offset. One combination gets special handling: the port is the work-RAM data window and the memory address also lies in work RAM. In that case the byte is either skipped with no bus access, or replaced by a constant fill value written to memory. The channel adds up the bus cycles the transfer costs and reports the total with a one-clock `done` pulse. Both buses are simple master ports: a request is held until the slave returns ready.

Top module: `dma_chan`

## Requirements
- R1: Register offsets are 0 control, 1 port, 2/3/4 memory address low/high/bank, 5/6 count low/high. Each readable register returns the value last written to it. Any access (read or write) at offset 7 raises `reg_bad` in the same cycle, reads there return 0, and writes there change nothing.
- R2: Control bits are: bit 7 direction (0 = memory to peripheral, 1 = peripheral to memory), bit 4 step down, bit 3 hold address, bits 2:0 mode.
- R3: The B address is 0x21 in the upper byte and (port + offset) mod 256 in the lower byte. Mode 1 uses offset 0 on even byte indices and offset 1 on odd ones. Every other mode uses offset 0 for every byte.
- R4: Memory to peripheral reads the A address, then writes the same byte to the B address. Peripheral to memory reads the B address, then writes that byte to the A address. A request and its address and data stay stable until ready. The two buses are never requested in the same cycle.
- R5: After each byte the low 16 address bits step by +1, or by -1 when bit 4 is set. They wrap modulo 65536 and stay unchanged when bit 3 is set. The bank byte never changes.
- R6: The count drops by one per byte and the transfer ends after the byte that brings it to 0. A programmed count of 0 therefore moves 65536 bytes.
- R7: Special case: port 0x80 with a bank of 0x7E or 0x7F. Memory to peripheral then makes no bus access and costs 8 cycles. Peripheral to memory makes no B access and writes 0xFF to the A address, costing 4 cycles.
- R8: `cycles` ends at 8 plus 8 per ordinary byte plus the special-case costs. `done` is high for exactly one clock, `busy` is already low in that clock, and `cycles` holds the total.
- R9: `go` while idle starts a transfer, raising `busy` on the next clock. `go` while busy is ignored. No bus is requested while idle.
- R10: Register writes while busy are ignored. Reads while busy return the live address and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for the invalid flag) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| reg_bad | output | 1 | Access at an offset outside the map |
| go | input | 1 | Start request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| cycles | output | 24 | Accumulated bus cycle cost |
| a_req | output | 1 | Memory bus request |
| a_we | output | 1 | Memory bus write enable |
| a_addr | output | 24 | Memory bus address |
| a_wdata | output | 8 | Memory bus write data |
| a_rdata | input | 8 | Memory bus read data |
| a_ready | input | 1 | Memory bus ready |
| b_req | output | 1 | Peripheral bus request |
| b_we | output | 1 | Peripheral bus write enable |
| b_addr | output | 16 | Peripheral bus address |
| b_wdata | output | 8 | Peripheral bus write data |
| b_rdata | input | 8 | Peripheral bus read data |
| b_ready | input | 1 | Peripheral bus ready |

## Verification
The bench targets several corner cases:
- The low address runs across 0xFFFF/0x0000 in both step directions. A bank carry or a 24-bit step would show up there as a wrong bank on the bus.
- A port of 0xFF in the alternating mode makes a design that lets the offset carry into the page byte emit 0x2200 instead of 0x2100.
- Both work-RAM special cases are run, along with a near miss at bank 0x7D. A wrong decode would then issue accesses that should be absent, or drop ones that should occur, and the cycle total would differ.
- A zero count runs the full 65536 bytes, which catches a loop that tests the count before moving a byte. During that run a register write and a second `go` must both leave no trace.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int AW    = 24;
    localparam int CW    = 16;
    localparam int DW    = 8;
    localparam int CYC_W = 24;
    localparam int OFS_W = 3;

    typedef enum logic {
        DIR_A2B = 1'b0,
        DIR_B2A = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e       dir;
        logic [1:0] spare;
        logic       down;
        logic       hold;
        logic [2:0] mode;
    } ctrl_t;

    localparam logic [2:0] MODE_SINGLE = 3'd0;
    localparam logic [2:0] MODE_PAIR   = 3'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRC,
        ST_DST,
        ST_STEP
    } st_e;

    localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_PORT  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_ALO   = 3'd2;
    localparam logic [OFS_W-1:0] OFS_AHI   = 3'd3;
    localparam logic [OFS_W-1:0] OFS_ABANK = 3'd4;
    localparam logic [OFS_W-1:0] OFS_CLO   = 3'd5;
    localparam logic [OFS_W-1:0] OFS_CHI   = 3'd6;
    localparam logic [OFS_W-1:0] OFS_LAST  = OFS_CHI;

    function automatic logic [DW-1:0] mode_offset(input logic [2:0] mode, input logic odd);
        case (mode)
            MODE_PAIR: return {{(DW-1){1'b0}}, odd};
            default:   return '0;
        endcase
    endfunction

    function automatic logic [15:0] next_low(input logic [15:0] cur, input logic down, input logic hold);
        if (hold)
            return cur;
        return down ? cur - 16'd1 : cur + 16'd1;
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [OFS_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             bad,
    input  logic             busy,
    input  logic             adv,
    output ctrl_t            ctrl_o,
    output logic [DW-1:0]    port_o,
    output logic [AW-1:0]    aaddr_o,
    output logic [CW-1:0]    count_o
);

    ctrl_t         ctrl_q;
    logic [DW-1:0] port_q;
    logic [AW-1:0] aaddr_q;
    logic [CW-1:0] count_q;
    logic          in_map;
    logic          wr_ok;

    assign in_map = (addr <= OFS_LAST);
    assign wr_ok  = wr && in_map && !busy;
    assign bad    = (wr || rd) && !in_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            port_q  <= '0;
            aaddr_q <= '0;
            count_q <= '0;
        end else if (adv) begin
            aaddr_q[15:0] <= next_low(aaddr_q[15:0], ctrl_q.down, ctrl_q.hold);
            count_q       <= count_q - 1'b1;
        end else if (wr_ok) begin
            case (addr)
                OFS_CTRL:  ctrl_q           <= ctrl_t'(wdata);
                OFS_PORT:  port_q           <= wdata;
                OFS_ALO:   aaddr_q[7:0]     <= wdata;
                OFS_AHI:   aaddr_q[15:8]    <= wdata;
                OFS_ABANK: aaddr_q[23:16]   <= wdata;
                OFS_CLO:   count_q[7:0]     <= wdata;
                OFS_CHI:   count_q[15:8]    <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL:  rdata = ctrl_q;
            OFS_PORT:  rdata = port_q;
            OFS_ALO:   rdata = aaddr_q[7:0];
            OFS_AHI:   rdata = aaddr_q[15:8];
            OFS_ABANK: rdata = aaddr_q[23:16];
            OFS_CLO:   rdata = count_q[7:0];
            OFS_CHI:   rdata = count_q[15:8];
            default:   rdata = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign port_o  = port_q;
    assign aaddr_o = aaddr_q;
    assign count_o = count_q;

    AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(aaddr_q[23:16])); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ctrl_q) && $stable(port_q))); // R10

endmodule

// File: rtl/dma_chan_route.sv
module dma_chan_route
    import dma_chan_pkg::*;
#(
    parameter logic [7:0] B_PAGE       = 8'h21,
    parameter logic [7:0] SPECIAL_PORT = 8'h80,
    parameter logic [7:0] WRAM_LO      = 8'h7E,
    parameter logic [7:0] WRAM_HI      = 8'h7F
) (
    input  ctrl_t          ctrl,
    input  logic [DW-1:0]  port,
    input  logic [AW-1:0]  aaddr,
    input  logic           odd,
    output logic [15:0]    b_addr,
    output logic           special
);

    logic [DW-1:0] window;
    logic [7:0]    bank;
    logic          wram_hit;

    assign window   = port + mode_offset(ctrl.mode, odd);
    assign b_addr   = {B_PAGE, window};
    assign bank     = aaddr[AW-1:AW-8];
    assign wram_hit = (bank >= WRAM_LO) && (bank <= WRAM_HI);
    assign special  = wram_hit && (port == SPECIAL_PORT);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int          COST_SETUP = 8,
    parameter int          COST_BYTE  = 8,
    parameter int          COST_SKIP  = 8,
    parameter int          COST_FILL  = 4,
    parameter logic [7:0]  FILL_VALUE = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  ctrl_t            ctrl,
    input  logic [CW-1:0]    count,
    input  logic             special,
    input  logic [DW-1:0]    a_rdata,
    input  logic             a_ready,
    input  logic [DW-1:0]    b_rdata,
    input  logic             b_ready,
    output logic             busy,
    output logic             adv,
    output logic             odd,
    output logic             done,
    output logic [CYC_W-1:0] cycles,
    output logic             a_req,
    output logic             a_we,
    output logic [DW-1:0]    a_wdata,
    output logic             b_req,
    output logic             b_we,
    output logic [DW-1:0]    b_wdata
);

    localparam logic [CYC_W-1:0] C_SETUP = CYC_W'(COST_SETUP);
    localparam logic [CYC_W-1:0] C_BYTE  = CYC_W'(COST_BYTE);
    localparam logic [CYC_W-1:0] C_SKIP  = CYC_W'(COST_SKIP);
    localparam logic [CYC_W-1:0] C_FILL  = CYC_W'(COST_FILL);

    st_e              st;
    logic [DW-1:0]    data_q;
    logic [CYC_W-1:0] acc_q;
    logic [CYC_W-1:0] cost_q;
    logic             odd_q;
    logic             done_q;
    logic             a2b;
    logic             src_ready;
    logic             dst_ready;
    logic [DW-1:0]    src_data;

    assign a2b       = (ctrl.dir == DIR_A2B);
    assign src_ready = a2b ? a_ready : b_ready;
    assign dst_ready = a2b ? b_ready : a_ready;
    assign src_data  = a2b ? a_rdata : b_rdata;

    always_comb begin
        a_req = 1'b0;
        a_we  = 1'b0;
        b_req = 1'b0;
        b_we  = 1'b0;
        case (st)
            ST_SRC: begin
                if (!special) begin
                    if (a2b) a_req = 1'b1;
                    else     b_req = 1'b1;
                end
            end
            ST_DST: begin
                if (a2b) begin
                    b_req = 1'b1;
                    b_we  = 1'b1;
                end else begin
                    a_req = 1'b1;
                    a_we  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            data_q <= '0;
            acc_q  <= '0;
            cost_q <= '0;
            odd_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st    <= ST_SRC;
                        acc_q <= C_SETUP;
                        odd_q <= 1'b0;
                    end
                end
                ST_SRC: begin
                    if (special) begin
                        if (a2b) begin
                            cost_q <= C_SKIP;
                            st     <= ST_STEP;
                        end else begin
                            data_q <= FILL_VALUE;
                            cost_q <= C_FILL;
                            st     <= ST_DST;
                        end
                    end else if (src_ready) begin
                        data_q <= src_data;
                        cost_q <= C_BYTE;
                        st     <= ST_DST;
                    end
                end
                ST_DST: begin
                    if (dst_ready)
                        st <= ST_STEP;
                end
                ST_STEP: begin
                    acc_q <= acc_q + cost_q;
                    odd_q <= ~odd_q;
                    if (count == CW'(1)) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        st <= ST_SRC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign adv     = (st == ST_STEP);
    assign odd     = odd_q;
    assign done    = done_q;
    assign cycles  = acc_q;
    assign a_wdata = data_q;
    assign b_wdata = data_q;

    AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
        !(a_req && b_req)); // R4

    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (a_req && !a_ready) |=> (a_req && $stable(a_we) && $stable(a_wdata))); // R4

    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (b_req && !b_ready) |=> (b_req && $stable(b_we) && $stable(b_wdata))); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!a_req && !b_req)); // R9

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter logic [7:0] B_PAGE       = 8'h21,
    parameter logic [7:0] SPECIAL_PORT = 8'h80,
    parameter logic [7:0] WRAM_LO      = 8'h7E,
    parameter logic [7:0] WRAM_HI      = 8'h7F,
    parameter int         COST_SETUP   = 8,
    parameter int         COST_BYTE    = 8,
    parameter int         COST_SKIP    = 8,
    parameter int         COST_FILL    = 4,
    parameter logic [7:0] FILL_VALUE   = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             reg_bad,
    input  logic             go,
    output logic             busy,
    output logic             done,
    output logic [23:0]      cycles,
    output logic             a_req,
    output logic             a_we,
    output logic [23:0]      a_addr,
    output logic [7:0]       a_wdata,
    input  logic [7:0]       a_rdata,
    input  logic             a_ready,
    output logic             b_req,
    output logic             b_we,
    output logic [15:0]      b_addr,
    output logic [7:0]       b_wdata,
    input  logic [7:0]       b_rdata,
    input  logic             b_ready
);

    ctrl_t         ctrl;
    logic [DW-1:0] port;
    logic [AW-1:0] aaddr;
    logic [CW-1:0] count;
    logic          adv;
    logic          odd;
    logic          special;

    dma_chan_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .bad     (reg_bad),
        .busy    (busy),
        .adv     (adv),
        .ctrl_o  (ctrl),
        .port_o  (port),
        .aaddr_o (aaddr),
        .count_o (count)
    );

    dma_chan_route #(
        .B_PAGE       (B_PAGE),
        .SPECIAL_PORT (SPECIAL_PORT),
        .WRAM_LO      (WRAM_LO),
        .WRAM_HI      (WRAM_HI)
    ) u_route (
        .ctrl    (ctrl),
        .port    (port),
        .aaddr   (aaddr),
        .odd     (odd),
        .b_addr  (b_addr),
        .special (special)
    );

    dma_chan_engine #(
        .COST_SETUP (COST_SETUP),
        .COST_BYTE  (COST_BYTE),
        .COST_SKIP  (COST_SKIP),
        .COST_FILL  (COST_FILL),
        .FILL_VALUE (FILL_VALUE)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .ctrl    (ctrl),
        .count   (count),
        .special (special),
        .a_rdata (a_rdata),
        .a_ready (a_ready),
        .b_rdata (b_rdata),
        .b_ready (b_ready),
        .busy    (busy),
        .adv     (adv),
        .odd     (odd),
        .done    (done),
        .cycles  (cycles),
        .a_req   (a_req),
        .a_we    (a_we),
        .a_wdata (a_wdata),
        .b_req   (b_req),
        .b_we    (b_we),
        .b_wdata (b_wdata)
    );

    assign a_addr = aaddr;

endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        reg_bad;
    logic        go = 1'b0;
    logic        busy;
    logic        done;
    logic [23:0] cycles;
    logic        a_req, a_we;
    logic [23:0] a_addr;
    logic [7:0]  a_wdata;
    logic [7:0]  a_rdata = 8'd0;
    logic        a_ready = 1'b0;
    logic        b_req, b_we;
    logic [15:0] b_addr;
    logic [7:0]  b_wdata;
    logic [7:0]  b_rdata = 8'd0;
    logic        b_ready = 1'b0;

    always #10 clk = ~clk;

    dma_chan u_dma_chan (
        .clk (clk), .rst (rst),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .reg_bad (reg_bad),
        .go (go), .busy (busy), .done (done), .cycles (cycles),
        .a_req (a_req), .a_we (a_we), .a_addr (a_addr), .a_wdata (a_wdata),
        .a_rdata (a_rdata), .a_ready (a_ready),
        .b_req (b_req), .b_we (b_we), .b_addr (b_addr), .b_wdata (b_wdata),
        .b_rdata (b_rdata), .b_ready (b_ready)
    );

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory and peripheral models
    logic [7:0] amem [int];

    function automatic logic [7:0] a_peek(input int ad);
        if (amem.exists(ad))
            return amem[ad];
        return 8'(ad ^ (ad >> 8) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] b_peek(input logic [15:0] ad);
        return ad[7:0] + 8'h33;
    endfunction

    typedef struct {
        bit         we;
        int         addr;
        logic [7:0] data;
        string      req;
    } txn_t;

    txn_t exp_a[$];
    txn_t exp_b[$];

    logic [15:0] lfsr = 16'hACE1;

    // Bus slaves and transaction checker, evaluated every clock
    always @(negedge clk) begin
        txn_t t;
        cyc++;
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a_ready = a_req && lfsr[0];
        b_ready = b_req && lfsr[3];
        if (!rst && a_req && b_req)
            chk(1'b0, "R4", "both buses requested", 1, 0);
        if (!rst && a_req && a_ready) begin
            if (!a_we) a_rdata = a_peek(int'(a_addr));
            else       amem[int'(a_addr)] = a_wdata;
            if (exp_a.size() == 0) begin
                chk(1'b0, "R4", "unexpected A access", longint'(a_addr), 0);
            end else begin
                t = exp_a.pop_front();
                chk(t.we == a_we && t.addr == int'(a_addr) && (!t.we || t.data == a_wdata),
                    t.req, "A access {we,addr,data}",
                    {31'd0, a_we, a_addr, a_wdata},
                    {31'd0, t.we, t.addr[23:0], (t.we ? t.data : a_wdata)});
            end
        end
        if (!rst && b_req && b_ready) begin
            if (!b_we) b_rdata = b_peek(b_addr);
            if (exp_b.size() == 0) begin
                chk(1'b0, "R4", "unexpected B access", longint'(b_addr), 0);
            end else begin
                t = exp_b.pop_front();
                chk(t.we == b_we && t.addr == int'(b_addr) && (!t.we || t.data == b_wdata),
                    t.req, "B access {we,addr,data}",
                    {39'd0, b_we, b_addr, b_wdata},
                    {39'd0, t.we, t.addr[15:0], (t.we ? t.data : b_wdata)});
            end
        end
        if (cyc > 195000) begin
            chk(1'b0, "WATCHDOG", "run did not finish", cyc, 195000);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic wr_reg(input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = o;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] o, output logic [7:0] d, output logic bad);
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = o;
        #1;
        d        = reg_rdata;
        bad      = reg_bad;
        reg_rd   = 1'b0;
    endtask

    task automatic run_xfer(input string tag, input logic [7:0] ctrl, input logic [7:0] port,
                            input logic [23:0] addr, input logic [15:0] count, input bit long_run);
        int          n;
        logic [15:0] lo;
        logic [7:0]  bank;
        int          exp_cyc;
        int          waited;
        logic [7:0]  d;
        logic        bad;
        bit          b2a, down, hold, special;
        logic [7:0]  off;
        logic [15:0] baddr;
        logic [23:0] full;
        txn_t        t;

        wr_reg(3'd0, ctrl);
        wr_reg(3'd1, port);
        wr_reg(3'd2, addr[7:0]);
        wr_reg(3'd3, addr[15:8]);
        wr_reg(3'd4, addr[23:16]);
        wr_reg(3'd5, count[7:0]);
        wr_reg(3'd6, count[15:8]);

        // Reference model: R2 bit layout, R3 window, R5 stepping, R6 length, R7 special case
        b2a     = ctrl[7];
        down    = ctrl[4];
        hold    = ctrl[3];
        n       = (count == 16'd0) ? 65536 : int'(count);
        lo      = addr[15:0];
        bank    = addr[23:16];
        exp_cyc = 8;
        special = (port == 8'h80) && (bank == 8'h7E || bank == 8'h7F);
        for (int i = 0; i < n; i++) begin
            full  = {bank, lo};
            off   = (ctrl[2:0] == 3'd1) ? 8'(i % 2) : 8'd0;
            baddr = {8'h21, 8'(port + off)};
            if (special) begin
                if (!b2a) begin
                    exp_cyc += 8;
                end else begin
                    t.we = 1'b1; t.addr = int'(full); t.data = 8'hFF; t.req = "R7";
                    exp_a.push_back(t);
                    exp_cyc += 4;
                end
            end else if (!b2a) begin
                t.we = 1'b0; t.addr = int'(full); t.data = 8'h00; t.req = "R5";
                exp_a.push_back(t);
                t.we = 1'b1; t.addr = int'(baddr); t.data = a_peek(int'(full)); t.req = "R3";
                exp_b.push_back(t);
                exp_cyc += 8;
            end else begin
                t.we = 1'b0; t.addr = int'(baddr); t.data = 8'h00; t.req = "R3";
                exp_b.push_back(t);
                t.we = 1'b1; t.addr = int'(full); t.data = b_peek(baddr); t.req = "R4";
                exp_a.push_back(t);
                exp_cyc += 8;
            end
            if (!hold)
                lo = down ? lo - 16'd1 : lo + 16'd1;
        end

        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        #2;
        chk(busy == 1'b1, "R9", {tag, " busy after go"}, busy, 1);

        waited = 0;
        forever begin
            @(negedge clk);
            #2;
            if (done) break;
            waited++;
            if (long_run && waited == 1000) begin
                wr_reg(3'd1, 8'h00);              // R10 write while busy
                rd_reg(3'd6, d, bad);
                chk(d == 8'hFE, "R10", {tag, " live count high byte"}, d, 8'hFE);
                rd_reg(3'd3, d, bad);
                chk(d == 8'h01, "R10", {tag, " live address high byte"}, d, 8'h01);
                @(negedge clk);
                go = 1'b1;                        // R9 go while busy
                @(negedge clk);
                go = 1'b0;
            end
        end

        chk(busy == 1'b0, "R8", {tag, " busy low with done"}, busy, 0);
        chk(cycles == 24'(exp_cyc), "R8", {tag, " cycle total"}, cycles, exp_cyc);
        chk(exp_a.size() == 0 && exp_b.size() == 0, "R4", {tag, " all transactions seen"},
            exp_a.size() + exp_b.size(), 0);
        exp_a.delete();
        exp_b.delete();

        @(negedge clk);
        #2;
        chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " done lasts one clock, no restart"},
            {done, busy}, 0);

        rd_reg(3'd5, d, bad);
        chk(d == 8'h00, "R6", {tag, " count low at end"}, d, 0);
        rd_reg(3'd6, d, bad);
        chk(d == 8'h00, "R6", {tag, " count high at end"}, d, 0);
        rd_reg(3'd2, d, bad);
        chk(d == lo[7:0], "R5", {tag, " address low at end"}, d, lo[7:0]);
        rd_reg(3'd3, d, bad);
        chk(d == lo[15:8], "R5", {tag, " address high at end"}, d, lo[15:8]);
        rd_reg(3'd4, d, bad);
        chk(d == bank, "R5", {tag, " bank unchanged"}, d, bank);
        if (long_run) begin
            rd_reg(3'd1, d, bad);
            chk(d == port, "R10", {tag, " port write while busy ignored"}, d, port);
        end
    endtask

    initial begin
        logic [7:0] d;
        logic       bad;
        logic [7:0] pat [7];

        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        chk(busy == 0 && done == 0 && cycles == 0, "R9", "reset state idle",
            {busy, done, cycles}, 0);
        chk(a_req == 0 && b_req == 0, "R9", "no requests after reset", {a_req, b_req}, 0);
        for (int i = 0; i < 7; i++) begin
            rd_reg(3'(i), d, bad);
            chk(d == 8'h00 && !bad, "R1", "register zero after reset", d, 0);
        end

        // R1 register map readback and invalid offset
        pat = '{8'h9B, 8'h47, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
        for (int i = 0; i < 7; i++)
            wr_reg(3'(i), pat[i]);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 8'h11;
        #1;
        chk(reg_bad == 1'b1, "R1", "write at offset 7 flagged", reg_bad, 1);
        @(negedge clk);
        reg_wr = 1'b0;
        for (int i = 0; i < 7; i++) begin
            rd_reg(3'(i), d, bad);
            chk(d == pat[i], "R1", "register readback", d, pat[i]);
        end
        rd_reg(3'd7, d, bad);
        chk(bad == 1'b1 && d == 8'h00, "R1", "read at offset 7 flagged and zero", {bad, d}, 9'h100);

        // R2/R4/R5: memory to peripheral, step up across the low wrap
        run_xfer("T1", 8'h00, 8'h18, 24'h12FFFE, 16'd5, 1'b0);
        // R3/R5: peripheral to memory, alternating mode, step down across zero
        run_xfer("T2", 8'h91, 8'h40, 24'h030001, 16'd4, 1'b0);
        // R3: held address, alternating mode, window wraps from 0xFF to 0x00
        run_xfer("T3", 8'h09, 8'hFF, 24'h001234, 16'd3, 1'b0);
        // R3: undefined mode code behaves as offset 0
        run_xfer("T4", 8'h05, 8'h22, 24'h450100, 16'd3, 1'b0);
        // R7: skip case, no bus accesses
        run_xfer("T5", 8'h00, 8'h80, 24'h7E2000, 16'd3, 1'b0);
        // R7: fill case, 0xFF written to memory
        run_xfer("T6", 8'h80, 8'h80, 24'h7F0010, 16'd2, 1'b0);
        // R7: same port, bank outside work RAM, ordinary transfer
        run_xfer("T7", 8'h00, 8'h80, 24'h7D0040, 16'd2, 1'b0);
        // R6: zero count moves 65536 bytes; R9/R10 checks during the run
        run_xfer("T8", 8'h00, 8'h80, 24'h7E0000, 16'd0, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule